// File: doc/BRIEF.md
# Burst-Aligning DMA Transfer Sequencer

This block is a bus-master DMA sequencer that moves a buffer of 32-bit words between a FIFO-side port and a simplified request/grant bus. A transfer is launched with a start pulse that carries a byte address, a word count and a direction. It also carries two burst permissions, one for reads and one for writes. The sequencer raises its bus request and waits for grant before each transaction. It then presents an address phase with a command code, followed by one or more data phases, each closed by a valid/ready handshake.

Software may hand over any word address. When bursting is permitted for the chosen direction but the working address is not on an aligned boundary, the sequencer issues single-word transactions and steps the address by four bytes after each one. It does this until the address lands on the boundary. It then switches to one linear burst that carries all remaining words, and it keeps the bus request up the whole time. With the matching permission clear, every word is its own single-word transaction. A one-cycle done pulse marks the end.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset, bus_req, bus_addr_valid, bus_dvalid and done are 0, bus_be_n is 4'b1111 and bus_cmd is 4'b0000.
- R2: A start with a non-zero count raises bus_req. bus_req stays 1 in every cycle until the final data phase is accepted, and it is 0 in the cycle that follows.
- R3: An address phase (bus_addr_valid = 1) occurs only in the cycle right after a cycle in which bus_gnt was 1 while requesting.
- R4: bus_addr carries the working word address during address and data phases. The address starts at start_addr with bits [1:0] cleared, and each accepted data phase (bus_dvalid and bus_dready both 1) advances it by 4.
- R5: With bursting permitted for the direction and bus_addr[3:0] not zero (default boundary of 16 bytes), each transaction has one address phase and one data phase, until bits [3:0] reach zero.
- R6: With bursting permitted and the working address aligned, a single transaction carries every remaining word, with no further address phase. A start at an aligned address bursts from its first word.
- R7: The read permission (burst_rd_en) governs reads only and the write permission (burst_wr_en) governs writes only. With the matching permission clear, every word is a single-word transaction.
- R8: Address-phase command is 4'b0110 for a single-word read, 4'b1110 for a burst read and 4'b0111 for any write. bus_be_n is 4'b0000 in data phases and 4'b1111 in address phases.
- R9: If the count runs out before the boundary is reached, the transfer ends with single-word transactions only (for example, offset 0x04 with 2 words gives two singles).
- R10: done is a one-cycle pulse in the cycle after the final accepted data phase. A start with count 0 gives done in the cycle after start, with no bus request.
- R11: On writes, bus_dvalid requires fifo_wvalid, bus_wdata equals fifo_wdata and fifo_wready marks each accepted phase. On reads, fifo_rvalid marks each accepted phase, with fifo_rdata equal to bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a transfer (sampled while idle) |
| start_addr | input | ADDR_W | Buffer byte address |
| word_count | input | CNT_W | Number of 32-bit words |
| dir_write | input | 1 | 1 = FIFO to bus (write), 0 = bus to FIFO (read) |
| burst_rd_en | input | 1 | Permit bursting on reads |
| burst_wr_en | input | 1 | Permit bursting on writes |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr_valid | output | 1 | Address phase strobe |
| bus_addr | output | ADDR_W | Working word address |
| bus_cmd | output | 4 | Command code in the address phase |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_dvalid | output | 1 | Data phase valid |
| bus_dready | input | 1 | Target ready for the data phase |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_rdata | input | DATA_W | Read data from the bus |
| fifo_wdata | input | DATA_W | Write data from the FIFO |
| fifo_wvalid | input | 1 | FIFO has write data |
| fifo_wready | output | 1 | Write word consumed |
| fifo_rdata | output | DATA_W | Read data to the FIFO |
| fifo_rvalid | output | 1 | Read word delivered |
| done | output | 1 | Transfer complete pulse |

## Verification
The risky coincidence is the final word being accepted in the same cycle that the working address steps onto the burst boundary. Both the end of the transfer and the single-to-burst switch are decided on that edge, and a wrong priority opens a spurious burst address phase or keeps the request up. The bench provokes this by sweeping every start offset inside the 16-byte window against word counts from one to six, for both directions, with the permission on and off, while grant, ready and FIFO valid stall on interleaved periodic patterns. Each run is judged against the arithmetically expected number of single-word transactions, the burst decision and the command of each address phase, and the exact cycle of done and of the request drop.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_ADDR = 2'd2,
      ST_DATA = 2'd3
   } seq_state_e;

   localparam logic [3:0] CMD_NONE      = 4'b0000;
   localparam logic [3:0] CMD_RD_SINGLE = 4'b0110;
   localparam logic [3:0] CMD_RD_BURST  = 4'b1110;
   localparam logic [3:0] CMD_WRITE     = 4'b0111;
   localparam logic [3:0] BE_ALL_ON     = 4'b0000;
   localparam logic [3:0] BE_ALL_OFF    = 4'b1111;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int AW        = 32,
   parameter int CW        = 12,
   parameter int ALIGN_LSB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [CW-1:0] load_cnt,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last,
   output logic          aligned
);
   localparam logic [AW-1:0] WORD_BYTES = AW'(4);
   localparam logic [CW-1:0] ONE_WORD   = CW'(1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         remain <= '0;
      end else if (load) begin
         addr   <= {load_addr[AW-1:2], 2'b00};
         remain <= load_cnt;
      end else if (step) begin
         addr   <= addr + WORD_BYTES;
         remain <= remain - ONE_WORD;
      end
   end

   assign last = (remain == ONE_WORD);

   generate
      if (ALIGN_LSB <= 2) begin : g_word_align
         assign aligned = 1'b1;
      end else begin : g_wide_align
         assign aligned = (addr[ALIGN_LSB-1:2] == '0);
      end
   endgenerate
endmodule

// File: rtl/dma_cmd_sel.sv
module dma_cmd_sel
   import dma_seq_pkg::*;
(
   input  logic       is_write,
   input  logic       rd_burst_ok,
   input  logic       wr_burst_ok,
   input  logic       aligned,
   output logic       use_burst,
   output logic [3:0] cmd
);
   logic permit;

   always_comb begin
      permit    = is_write ? wr_burst_ok : rd_burst_ok;
      use_burst = permit && aligned;
      if (is_write)       cmd = CMD_WRITE;
      else if (use_burst) cmd = CMD_RD_BURST;
      else                cmd = CMD_RD_SINGLE;
   end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CNT_W       = 12,
   parameter int DATA_W      = 32,
   parameter int ALIGN_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  word_count,
   input  logic              dir_write,
   input  logic              burst_rd_en,
   input  logic              burst_wr_en,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_addr_valid,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [3:0]        bus_cmd,
   output logic [3:0]        bus_be_n,
   output logic              bus_dvalid,
   input  logic              bus_dready,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] fifo_wdata,
   input  logic              fifo_wvalid,
   output logic              fifo_wready,
   output logic [DATA_W-1:0] fifo_rdata,
   output logic              fifo_rvalid,
   output logic              done
);
   localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

   generate
      if (ALIGN_BYTES < 4 || (ALIGN_BYTES & (ALIGN_BYTES - 1)) != 0) begin : g_bad_align
         $error("ALIGN_BYTES must be a power of two of at least 4");
      end
      if (ADDR_W <= ALIGN_LSB) begin : g_bad_addr
         $error("ADDR_W must exceed the alignment bit count");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic       dir_q, rd_ok_q, wr_ok_q, burst_q, done_q;
   logic       load, accept, ctr_last, ctr_aligned, use_burst;
   logic [3:0] sel_cmd;

   assign load   = (state_q == ST_IDLE) && start && (word_count != '0);
   assign accept = bus_dvalid && bus_dready;

   dma_addr_ctr #(
      .AW        (ADDR_W),
      .CW        (CNT_W),
      .ALIGN_LSB (ALIGN_LSB)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (start_addr),
      .load_cnt  (word_count),
      .step      (accept),
      .addr      (bus_addr),
      .last      (ctr_last),
      .aligned   (ctr_aligned)
   );

   dma_cmd_sel u_cmd (
      .is_write    (dir_q),
      .rd_burst_ok (rd_ok_q),
      .wr_burst_ok (wr_ok_q),
      .aligned     (ctr_aligned),
      .use_burst   (use_burst),
      .cmd         (sel_cmd)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (load)    state_d = ST_REQ;
         ST_REQ:  if (bus_gnt) state_d = ST_ADDR;
         ST_ADDR:              state_d = ST_DATA;
         ST_DATA: begin
            if (accept) begin
               if (ctr_last)     state_d = ST_IDLE;
               else if (!burst_q) state_d = ST_REQ;
            end
         end
         default:              state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         rd_ok_q <= 1'b0;
         wr_ok_q <= 1'b0;
         burst_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= ((state_q == ST_IDLE) && start && (word_count == '0)) ||
                    ((state_q == ST_DATA) && accept && ctr_last);
         if (load) begin
            dir_q   <= dir_write;
            rd_ok_q <= burst_rd_en;
            wr_ok_q <= burst_wr_en;
         end
         if (state_q == ST_ADDR) burst_q <= use_burst;
      end
   end

   assign bus_req        = (state_q != ST_IDLE);
   assign bus_addr_valid = (state_q == ST_ADDR);
   assign bus_cmd        = (state_q == ST_ADDR) ? sel_cmd : CMD_NONE;
   assign bus_be_n       = (state_q == ST_DATA) ? BE_ALL_ON : BE_ALL_OFF;
   assign bus_dvalid     = (state_q == ST_DATA) && (!dir_q || fifo_wvalid);
   assign bus_wdata      = fifo_wdata;
   assign fifo_wready    = accept && dir_q;
   assign fifo_rvalid    = accept && !dir_q;
   assign fifo_rdata     = bus_rdata;
   assign done           = done_q;
endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
   parameter int AW        = 32,
   parameter int ALIGN_LSB = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_addr_valid,
   input logic [AW-1:0] bus_addr,
   input logic [3:0]    bus_cmd,
   input logic [3:0]    bus_be_n,
   input logic          bus_dvalid,
   input logic          bus_dready,
   input logic          done,
   input logic          word_last
);
   logic acc;
   assign acc = bus_dvalid && bus_dready;

   // R2: request is only withdrawn after the final word is accepted
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !(acc && word_last)) |=> bus_req);

   // R3: address phase follows a sampled grant
   assert_addr_after_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |-> $past(bus_gnt));

   // R4: each accepted word steps the address by four bytes
   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (bus_addr == $past(bus_addr) + AW'(4)));

   // R5: burst reads open only on an aligned address
   assert_burst_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_valid && bus_cmd == 4'b1110) |-> (bus_addr[ALIGN_LSB-1:0] == '0));

   // R8: legal command codes and byte enables
   assert_cmd_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |-> (bus_cmd == 4'b0110 || bus_cmd == 4'b1110 || bus_cmd == 4'b0111));
   assert_be_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dvalid |-> (bus_be_n == 4'b0000));

   // R10: done never coincides with an open request
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);
endmodule

bind dma_burst_seq dma_burst_seq_chk #(
   .AW        (ADDR_W),
   .ALIGN_LSB (ALIGN_LSB)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_req        (bus_req),
   .bus_gnt        (bus_gnt),
   .bus_addr_valid (bus_addr_valid),
   .bus_addr       (bus_addr),
   .bus_cmd        (bus_cmd),
   .bus_be_n       (bus_be_n),
   .bus_dvalid     (bus_dvalid),
   .bus_dready     (bus_dready),
   .done           (done),
   .word_last      (ctr_last)
);

// File: tb/dma_burst_seq_bench.sv
module dma_burst_seq_bench;
   localparam int AW = 32;
   localparam int CW = 12;
   localparam int DW = 32;
   localparam logic [DW-1:0] WBASE = 32'hA000_0000;
   localparam logic [DW-1:0] RMASK = 32'h5A5A_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [CW-1:0] word_count = '0;
   logic dir_write = 1'b0, burst_rd_en = 1'b0, burst_wr_en = 1'b0;
   logic bus_req, bus_addr_valid, bus_dvalid, fifo_wready, fifo_rvalid, done;
   logic bus_gnt = 1'b0, bus_dready = 1'b0, fifo_wvalid = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [3:0] bus_cmd, bus_be_n;
   logic [DW-1:0] bus_wdata, fifo_rdata;
   logic [DW-1:0] bus_rdata = '0, fifo_wdata = '0;

   int checks = 0, fails = 0, cyc = 0, widx = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dma_burst_seq u_dma_burst_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .dir_write(dir_write), .burst_rd_en(burst_rd_en),
      .burst_wr_en(burst_wr_en), .bus_req(bus_req), .bus_gnt(bus_gnt),
      .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
      .bus_be_n(bus_be_n), .bus_dvalid(bus_dvalid), .bus_dready(bus_dready),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_wdata(fifo_wdata),
      .fifo_wvalid(fifo_wvalid), .fifo_wready(fifo_wready), .fifo_rdata(fifo_rdata),
      .fifo_rvalid(fifo_rvalid), .done(done)
   );

   // stall patterns and data sources, changed just after each rising edge
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      bus_gnt     = (cyc % 5) != 3;
      bus_dready  = (cyc % 3) != 1;
      fifo_wvalid = (cyc % 7) != 2;
      fifo_wdata  = WBASE + DW'(widx);
      bus_rdata   = bus_addr ^ RMASK;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic run(input int off, input int n, input bit wr, input bit en);
      logic [AW-1:0] base;
      int span, s, exp_ap, ap, w, req_bad, cmd_bad, dat_bad, gnt_bad, be_bad;
      int last_at, done_at, done_cnt, drop_bad;
      bit burst, prev_gnt;
      string tag;
      base = 32'h1000_0100 + AW'(off) + AW'(64 * n);
      span = ((16 - off) & 15) / 4;
      s = en ? ((n < span) ? n : span) : n;
      burst = en && (n > s);
      exp_ap = s + (burst ? 1 : 0);
      ap = 0; w = 0; req_bad = 0; cmd_bad = 0; dat_bad = 0; gnt_bad = 0; be_bad = 0;
      last_at = -1; done_at = -1; done_cnt = 0; drop_bad = 0; prev_gnt = 1'b0;
      widx = 0;
      @(posedge clk); #1;
      start = 1'b1; start_addr = base; word_count = CW'(n); dir_write = wr;
      burst_rd_en = wr ? !en : en;
      burst_wr_en = wr ? en : !en;
      @(posedge clk); #1;
      start = 1'b0;
      for (int t = 0; t < 400 && done_at < 0; t++) begin
         @(negedge clk);
         if (bus_addr_valid) begin
            logic [3:0] ec;
            if (!prev_gnt) gnt_bad++;
            ec = wr ? 4'b0111 : ((ap < s) ? 4'b0110 : 4'b1110);
            if (bus_cmd != ec || bus_addr != base + AW'(4 * ap) || bus_be_n != 4'b1111)
               cmd_bad++;
            ap++;
         end
         if (bus_dvalid && bus_be_n != 4'b0000) be_bad++;
         if (last_at < 0 && !bus_req) req_bad++;
         if (last_at >= 0 && t == last_at + 1 && bus_req) drop_bad++;
         if (done) begin done_cnt++; done_at = t; end
         if (bus_dvalid && bus_dready) begin
            if (bus_addr != base + AW'(4 * w)) dat_bad++;
            if (wr && (!fifo_wready || fifo_rvalid || bus_wdata != WBASE + DW'(w))) dat_bad++;
            if (!wr && (!fifo_rvalid || fifo_wready ||
                        fifo_rdata != ((base + AW'(4 * w)) ^ RMASK))) dat_bad++;
            w++;
            widx = w;
            if (w == n) last_at = t;
         end
         prev_gnt = bus_gnt;
      end
      @(negedge clk);
      if (done) done_cnt++;
      if (!en)               tag = "R7";
      else if (!burst && off != 0) tag = "R9";
      else if (off == 0)     tag = "R6";
      else                   tag = "R5";
      check(ap == exp_ap, tag, "address phase count", ap, exp_ap);
      check(cmd_bad == 0, "R8", "command/address per phase", cmd_bad, 0);
      check(be_bad == 0, "R8", "byte enables in data phase", be_bad, 0);
      check(gnt_bad == 0, "R3", "address phase without grant", gnt_bad, 0);
      check(w == n && dat_bad == 0, "R4", "words moved", w, n);
      check(dat_bad == 0, "R11", "data/handshake mismatches", dat_bad, 0);
      check(req_bad == 0 && drop_bad == 0, "R2", "request continuity", req_bad + drop_bad, 0);
      check(done_cnt == 1 && done_at == last_at + 1, "R10", "done timing",
            done_at, last_at + 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!bus_req && !bus_addr_valid && !bus_dvalid && !done, "R1", "idle strobes",
            {bus_req, bus_addr_valid, bus_dvalid, done}, 0);
      check(bus_be_n == 4'b1111 && bus_cmd == 4'b0000, "R1", "idle codes",
            {bus_be_n, bus_cmd}, 8'hF0);

      // zero-length transfer
      @(posedge clk); #1;
      start = 1'b1; word_count = '0; start_addr = 32'h2000_0004;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      check(done && !bus_req, "R10", "count zero done", {done, bus_req}, 2'b10);
      @(negedge clk);
      check(!done && !bus_req, "R10", "count zero single pulse", {done, bus_req}, 2'b00);

      for (int wr = 0; wr < 2; wr++)
         for (int en = 0; en < 2; en++)
            for (int off = 0; off < 16; off += 4)
               for (int n = 1; n <= 6; n++)
                  run(off, n, wr[0], en[0]);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule